// File: doc/BRIEF.md
# Interruption address capture unit

This block keeps the two 64-bit address registers that a processor core loads when an interruption is taken. The first is the saved instruction pointer. The second is the faulting address. On an interruption strobe the unit formats each value according to the fault kind and the addressing mode, and writes it. On the return path it presents a restart target, built from the saved instruction pointer, in which the bits that the target instruction set ignores read as zero.

When an instruction address lies outside the implemented range, the saved pointer is written in one of two forms. A parameter picks the truncated form or the full address. In the truncated form, a virtual address (translation on) is sign-extended from its top implemented bit and keeps its three region bits. A physical address (translation off) keeps bit 63 and has the unimplemented bits above the implemented range cleared. If that fault came from a return, a second parameter can leave the saved pointer as it was. Privileged software can load either register directly. A software write is dropped in any cycle that carries an interruption.

Top module: `irq_addr_capture`

## Requirements
- R1: After reset both `iip_o` and `ifa_o` read 0.
- R2: On `intr_i` with `fault_kind_i` 0 (external), 1 (instruction fetch) or 2 (data), `iip_o` takes `ip_i` on the next clock.
- R3: On `intr_i` with `ic_i`=1, `ifa_o` takes `fault_addr_i` with bits 3:0 cleared for kind 1, and `fault_addr_i` unchanged for kind 2. For kinds 0 and 3, `ifa_o` keeps its value.
- R4: On `intr_i` with `ic_i`=0, `ifa_o` keeps its value for every fault kind.
- R5: Consider kind 3 (unimplemented instruction address) with `xlat_en_i`=1, truncation enabled, and the saved pointer not preserved. `iip_o` takes `ip_i` with bits 63:61 and VA_MSB:0 kept, and bits 60 down to VA_MSB+1 equal to `ip_i[VA_MSB]`.
- R6: The same case with `xlat_en_i`=0 writes `ip_i` with bit 63 and bits PA_MSB:0 kept and bits 62 down to PA_MSB+1 cleared.
- R7: With truncation disabled (TRUNC_UNIMPL=0), kind 3 writes the full `ip_i` into `iip_o`.
- R8: Kind 3 with `ret_src_i`=1 leaves `iip_o` unchanged when KEEP_ON_RET_FAULT=1. When the parameter is 0 it writes the value given by R5, R6 or R7.
- R9: With `ret_is_i`=0, `restart_o` equals `iip_o` with bits 3:0 forced to 0.
- R10: With `ret_is_i`=1, `restart_o` equals `iip_o` with bits 63:32 forced to 0.
- R11: `ip_unimpl_o` is combinationally 1 when `xlat_en_i`=1 and any of `ip_i[60:VA_MSB+1]` differs from `ip_i[VA_MSB]`, or when `xlat_en_i`=0 and any of `ip_i[62:PA_MSB+1]` is 1. Otherwise it is 0.
- R12: `sw_we_i` loads `sw_wdata_i` on the next clock, into `iip_o` when `sw_sel_i`=0 and into `ifa_o` when `sw_sel_i`=1. A software write in a cycle with `intr_i`=1 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| intr_i | input | 1 | Interruption strobe |
| fault_kind_i | input | 2 | 0 external, 1 instruction fetch, 2 data, 3 unimplemented instruction address |
| ret_src_i | input | 1 | The interruption was raised by a return |
| ip_i | input | 64 | Current instruction pointer |
| fault_addr_i | input | 64 | Faulting address |
| xlat_en_i | input | 1 | Translation enabled (virtual addressing) |
| ic_i | input | 1 | Collection enable |
| ret_is_i | input | 1 | Target instruction set of the return: 0 native, 1 32-bit |
| sw_we_i | input | 1 | Software write strobe |
| sw_sel_i | input | 1 | Software write target: 0 saved pointer, 1 fault address |
| sw_wdata_i | input | 64 | Software write data |
| iip_o | output | 64 | Saved instruction pointer |
| ifa_o | output | 64 | Saved fault address |
| restart_o | output | 64 | Masked restart target |
| ip_unimpl_o | output | 1 | `ip_i` is outside the implemented range |

## Verification
An interruption and a software write can land in the same cycle. Every swept interruption is therefore driven together with a software write of a distinct value. The write is aimed at the saved pointer on some iterations and at the fault address on others. Each register is then compared with a bench model that discards the software value, including where the interruption itself leaves the target register untouched (collection off, external faults, preserved returns).

// File: rtl/iac_pkg.sv
package iac_pkg;
  localparam int unsigned XLEN = 64;
  localparam int unsigned NREG = 2;
  localparam int unsigned SEL_IIP = 0;
  localparam int unsigned SEL_IFA = 1;

  typedef enum logic [1:0] {
    FK_EXT    = 2'd0,
    FK_INST   = 2'd1,
    FK_DATA   = 2'd2,
    FK_UNIMPL = 2'd3
  } fault_kind_e;
endpackage

// File: rtl/iac_fmt.sv
module iac_fmt
  import iac_pkg::*;
#(
  parameter int unsigned VA_MSB = 50,
  parameter int unsigned PA_MSB = 49,
  parameter bit          TRUNC  = 1'b1
) (
  input  logic [XLEN-1:0] ip_i,
  input  logic            virt_i,
  output logic [XLEN-1:0] fmt_o,
  output logic            unimpl_o
);
  localparam int unsigned VA_FILL = 60 - VA_MSB;
  localparam int unsigned PA_FILL = 62 - PA_MSB;

  logic va_bad, pa_bad;
  logic [XLEN-1:0] va_fmt, pa_fmt;

  assign va_bad   = ip_i[60:VA_MSB+1] != {VA_FILL{ip_i[VA_MSB]}};
  assign pa_bad   = |ip_i[62:PA_MSB+1];
  assign unimpl_o = virt_i ? va_bad : pa_bad;

  assign va_fmt = {ip_i[63:61], {VA_FILL{ip_i[VA_MSB]}}, ip_i[VA_MSB:0]};
  assign pa_fmt = {ip_i[63], {PA_FILL{1'b0}}, ip_i[PA_MSB:0]};

  generate
    if (TRUNC) begin : g_trunc
      assign fmt_o = virt_i ? va_fmt : pa_fmt;
    end else begin : g_full
      assign fmt_o = ip_i;
    end
  endgenerate
endmodule

// File: rtl/iac_cr_reg.sv
module iac_cr_reg
  import iac_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            hw_we_i,
  input  logic [XLEN-1:0] hw_d_i,
  input  logic            sw_we_i,
  input  logic [XLEN-1:0] sw_d_i,
  output logic [XLEN-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (hw_we_i) q_o <= hw_d_i;
    else if (sw_we_i) q_o <= sw_d_i;
  end

  a_r12_hw_first: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hw_we_i |=> q_o == $past(hw_d_i));
  a_r12_sw_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_we_i && !hw_we_i) |=> q_o == $past(sw_d_i));
endmodule

// File: rtl/iac_restart.sv
module iac_restart
  import iac_pkg::*;
(
  input  logic [XLEN-1:0] iip_i,
  input  logic            is32_i,
  output logic [XLEN-1:0] tgt_o
);
  localparam int unsigned HALF = XLEN / 2;

  always_comb begin
    tgt_o = iip_i;
    if (is32_i) tgt_o[XLEN-1:HALF] = '0;
    else        tgt_o[3:0]         = '0;
  end
endmodule

// File: rtl/irq_addr_capture.sv
module irq_addr_capture
  import iac_pkg::*;
#(
  parameter int unsigned VA_MSB            = 50,
  parameter int unsigned PA_MSB            = 49,
  parameter bit          TRUNC_UNIMPL      = 1'b1,
  parameter bit          KEEP_ON_RET_FAULT = 1'b1
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            intr_i,
  input  logic [1:0]      fault_kind_i,
  input  logic            ret_src_i,
  input  logic [XLEN-1:0] ip_i,
  input  logic [XLEN-1:0] fault_addr_i,
  input  logic            xlat_en_i,
  input  logic            ic_i,
  input  logic            ret_is_i,
  input  logic            sw_we_i,
  input  logic            sw_sel_i,
  input  logic [XLEN-1:0] sw_wdata_i,
  output logic [XLEN-1:0] iip_o,
  output logic [XLEN-1:0] ifa_o,
  output logic [XLEN-1:0] restart_o,
  output logic            ip_unimpl_o
);
  fault_kind_e     kind;
  logic [XLEN-1:0] ip_fmt;
  logic            keep_iip;

  logic            hw_we [NREG];
  logic [XLEN-1:0] hw_d  [NREG];
  logic            sw_we [NREG];
  logic [XLEN-1:0] q     [NREG];

  assign kind = fault_kind_e'(fault_kind_i);

  iac_fmt #(.VA_MSB(VA_MSB), .PA_MSB(PA_MSB), .TRUNC(TRUNC_UNIMPL)) u_fmt (
    .ip_i    (ip_i),
    .virt_i  (xlat_en_i),
    .fmt_o   (ip_fmt),
    .unimpl_o(ip_unimpl_o)
  );

  // a faulting return may preserve the prior saved pointer
  assign keep_iip = KEEP_ON_RET_FAULT && ret_src_i && (kind == FK_UNIMPL);

  always_comb begin
    hw_we[SEL_IIP] = intr_i && !keep_iip;
    hw_d[SEL_IIP]  = (kind == FK_UNIMPL) ? ip_fmt : ip_i;
    hw_we[SEL_IFA] = intr_i && ic_i && (kind == FK_INST || kind == FK_DATA);
    hw_d[SEL_IFA]  = (kind == FK_INST) ? {fault_addr_i[XLEN-1:4], 4'h0} : fault_addr_i;
    sw_we[SEL_IIP] = sw_we_i && !sw_sel_i && !intr_i;
    sw_we[SEL_IFA] = sw_we_i &&  sw_sel_i && !intr_i;
  end

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_cr
      iac_cr_reg u_reg (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .hw_we_i(hw_we[g]),
        .hw_d_i (hw_d[g]),
        .sw_we_i(sw_we[g]),
        .sw_d_i (sw_wdata_i),
        .q_o    (q[g])
      );
    end
  endgenerate

  assign iip_o = q[SEL_IIP];
  assign ifa_o = q[SEL_IFA];

  iac_restart u_restart (
    .iip_i (iip_o),
    .is32_i(ret_is_i),
    .tgt_o (restart_o)
  );

  a_r1_reset: assert property (@(posedge clk_i)
    !rst_ni |=> (iip_o == '0) && (ifa_o == '0));
  a_r2_iip_take: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && kind != FK_UNIMPL) |=> iip_o == $past(ip_i));
  a_r3_inst_align: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && ic_i && kind == FK_INST) |=> ifa_o[3:0] == 4'h0);
  a_r3_data_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && ic_i && kind == FK_DATA) |=> ifa_o == $past(fault_addr_i));
  a_r4_ic_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && !ic_i) |=> $stable(ifa_o));
  a_r5_va_sext: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TRUNC_UNIMPL && intr_i && kind == FK_UNIMPL && xlat_en_i && !keep_iip)
      |=> iip_o[60:VA_MSB+1] == {(60-VA_MSB){iip_o[VA_MSB]}});
  a_r6_pa_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (TRUNC_UNIMPL && intr_i && kind == FK_UNIMPL && !xlat_en_i && !keep_iip)
      |=> iip_o[62:PA_MSB+1] == '0);
  a_r8_keep: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (KEEP_ON_RET_FAULT && intr_i && ret_src_i && kind == FK_UNIMPL) |=> $stable(iip_o));
  a_r9_native_low: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ret_is_i |-> (restart_o[3:0] == 4'h0) && (restart_o[XLEN-1:4] == iip_o[XLEN-1:4]));
  a_r10_ia32_high: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ret_is_i |-> (restart_o[XLEN-1:32] == '0) && (restart_o[31:0] == iip_o[31:0]));
  a_r12_sw_dropped: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (intr_i && sw_we_i && sw_sel_i && !ic_i) |=> $stable(ifa_o));
endmodule

// File: tb/sim_irq_addr_capture.sv
`timescale 1ns/100ps
module sim_irq_addr_capture;
  localparam int VA = 20;
  localparam int PA = 16;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        intr_i = 1'b0;
  logic [1:0]  fault_kind_i = '0;
  logic        ret_src_i = 1'b0;
  logic [63:0] ip_i = '0;
  logic [63:0] fault_addr_i = '0;
  logic        xlat_en_i = 1'b0;
  logic        ic_i = 1'b0;
  logic        ret_is_i = 1'b0;
  logic        sw_we_i = 1'b0;
  logic        sw_sel_i = 1'b0;
  logic [63:0] sw_wdata_i = '0;
  logic [63:0] iip0, ifa0, rst0, iip1, ifa1, rst1;
  logic        un0, un1;

  int checks = 0;
  int errors = 0;
  logic [63:0] m0_iip, m0_ifa, m1_iip, m1_ifa;

  always #2.5 clk_i = ~clk_i;

  irq_addr_capture #(.VA_MSB(VA), .PA_MSB(PA), .TRUNC_UNIMPL(1'b1), .KEEP_ON_RET_FAULT(1'b1)) u0 (
    .clk_i, .rst_ni, .intr_i, .fault_kind_i, .ret_src_i, .ip_i, .fault_addr_i,
    .xlat_en_i, .ic_i, .ret_is_i, .sw_we_i, .sw_sel_i, .sw_wdata_i,
    .iip_o(iip0), .ifa_o(ifa0), .restart_o(rst0), .ip_unimpl_o(un0));

  irq_addr_capture #(.VA_MSB(VA), .PA_MSB(PA), .TRUNC_UNIMPL(1'b0), .KEEP_ON_RET_FAULT(1'b0)) u1 (
    .clk_i, .rst_ni, .intr_i, .fault_kind_i, .ret_src_i, .ip_i, .fault_addr_i,
    .xlat_en_i, .ic_i, .ret_is_i, .sw_we_i, .sw_sel_i, .sw_wdata_i,
    .iip_o(iip1), .ifa_o(ifa1), .restart_o(rst1), .ip_unimpl_o(un1));

  task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [63:0] va_trunc(input logic [63:0] p);
    logic [63:0] r = p;
    for (int b = VA + 1; b <= 60; b++) r[b] = p[VA];
    return r;
  endfunction

  function automatic logic [63:0] pa_trunc(input logic [63:0] p);
    logic [63:0] r = p;
    for (int b = PA + 1; b <= 62; b++) r[b] = 1'b0;
    return r;
  endfunction

  function automatic logic bad_addr(input logic [63:0] p, input logic virt);
    logic r = 1'b0;
    if (virt) begin
      for (int b = VA + 1; b <= 60; b++) if (p[b] != p[VA]) r = 1'b1;
    end else begin
      for (int b = PA + 1; b <= 62; b++) if (p[b]) r = 1'b1;
    end
    return r;
  endfunction

  task automatic clock;
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  initial begin
    #(5.0 * 190000);
    errors++;
    $display("FAIL watchdog act=running exp=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk(iip0, 64'h0, "R1 iip u0"); chk(ifa0, 64'h0, "R1 ifa u0");
    chk(iip1, 64'h0, "R1 iip u1"); chk(ifa1, 64'h0, "R1 ifa u1");
    rst_ni = 1'b1;
    clock();
    m0_iip = '0; m0_ifa = '0; m1_iip = '0; m1_ifa = '0;

    for (int i = 0; i < 64; i++) begin
      logic [63:0] p, q, f, w, exp0, exp1;
      logic [1:0]  k;
      logic        ic, it, rs, sel;
      p = 64'h9E37_79B9_7F4A_7C15 * (i + 1);
      q = (64'hC2B2_AE3D_27D4_EB4F * (i + 7)) ^ {p[31:0], p[63:32]};
      if (i % 3 == 0) q = (i % 2 == 0) ? va_trunc(q) : pa_trunc(q);
      f = 64'h1656_67B1_9E37_79F9 * (i + 3);
      w = ~q;
      k = i[1:0]; ic = i[2]; it = i[3]; rs = i[4]; sel = i[5] ^ i[0];

      // R12 software load of the saved pointer, then the fault address
      sw_we_i = 1'b1; sw_sel_i = 1'b0; sw_wdata_i = p;
      clock();
      sw_sel_i = 1'b1; sw_wdata_i = f ^ 64'h5A;
      m0_iip = p; m1_iip = p;
      chk(iip0, p, "R12 sw iip u0"); chk(iip1, p, "R12 sw iip u1");
      clock();
      sw_we_i = 1'b0;
      m0_ifa = f ^ 64'h5A; m1_ifa = f ^ 64'h5A;
      chk(ifa0, m0_ifa, "R12 sw ifa u0");

      // R9 and R10 restart masking
      ret_is_i = 1'b0; #1;
      chk(rst0, {p[63:4], 4'h0}, "R9 native restart");
      ret_is_i = 1'b1; #1;
      chk(rst0, {32'h0, p[31:0]}, "R10 ia32 restart");

      // interruption together with a conflicting software write
      intr_i = 1'b1; fault_kind_i = k; ic_i = ic; xlat_en_i = it; ret_src_i = rs;
      ip_i = q; fault_addr_i = f;
      sw_we_i = 1'b1; sw_sel_i = sel; sw_wdata_i = w;
      #1;
      chk({63'h0, un0}, {63'h0, bad_addr(q, it)}, "R11 unimpl check");

      if (k != 2'd3) begin
        exp0 = q; exp1 = q;
      end else begin
        exp0 = rs ? m0_iip : (it ? va_trunc(q) : pa_trunc(q));
        exp1 = q;
      end
      m0_iip = exp0; m1_iip = exp1;
      if (ic && k == 2'd1) begin m0_ifa = {f[63:4], 4'h0}; m1_ifa = m0_ifa; end
      if (ic && k == 2'd2) begin m0_ifa = f; m1_ifa = f; end

      clock();
      intr_i = 1'b0; sw_we_i = 1'b0;
      if (k == 2'd3)
        chk(iip0, m0_iip, rs ? "R8 keep on return fault" : (it ? "R5 va trunc" : "R6 pa trunc"));
      else
        chk(iip0, m0_iip, "R2 iip capture");
      chk(iip1, m1_iip, (k == 2'd3) ? "R7 full address and R8 no keep" : "R2 iip capture u1");
      chk(ifa0, m0_ifa, ic ? "R3 ifa format" : "R4 ifa held ic off");
      chk(ifa1, m1_ifa, "R12 sw dropped ifa u1");
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule